// File: doc/BRIEF.md
# Miss Status Holding Register Unit

This unit keeps track of cache misses that a multi-warp processor core still has outstanding. Each miss request arrives with a line address, the warp that raised it and a set of kind flags. An accepted request takes the lowest-numbered free entry in the same cycle. When the request hits a line that is already outstanding, it is linked behind that line's entry and is not sent to memory a second time.

A memory response names a primary entry and marks it fetched. For ordinary misses, that primary then goes into the return path, followed by every entry that was linked behind it, in the order they were linked. Texture misses take a separate in-order path. Its oldest entry is released only once that entry itself has been fetched. The consumer sees one head entry at a time and pops it. Popping frees the entry for reuse.

The unit also answers a room query: are N entries free at once? It keeps the highest occupancy it has seen since reset.

Top module: `mshr_unit`

## Requirements
- R1: After reset all ENTRIES entries are free, `free_count` equals ENTRIES, `ret_valid` is 0 and `peak_used` is 0.
- R2: A request with `req_valid` high is accepted in the same cycle whenever any entry is free. It is given the lowest-numbered free entry. When no entry is free, `req_accept` is 0 and no entry changes.
- R3: A request is merged when all of the following hold:
  - the request is not a texture miss (`req_kind` bit 2 clear);
  - its address equals that of an in-flight, unmerged, non-texture primary entry.
  
  A merged request shows `req_merged`=1 and `mem_issue`=0. Every other accepted request shows `req_merged`=0 and `mem_issue`=1.
- R4: A request is never merged in these cases: it is a texture miss; the only matching entry is a texture miss; the only matching entry has already been fetched.
- R5: A response to a non-texture primary makes that primary the next normal return. The entries merged behind it follow, in the order they were merged, and nothing else comes between them.
- R6: Texture entries return in allocation order. The oldest texture entry is presented only after its own response has arrived, even if younger texture entries are already fetched.
- R7: When a normal return and a fetched texture head are both ready, the normal return is presented first.
- R8: `room_ok` is 1 exactly when `free_count` is at least `room_need`.
- R9: Popping a presented entry (`ret_pop` with `ret_valid`) frees it. `free_count` rises by one in the next cycle, and the entry can be allocated again.
- R10: `peak_used` never decreases. It always equals the largest number of entries held at once since reset.
- R11: `ret_addr`, `ret_warp` and `ret_kind` give the address, warp and kind flags stored for `ret_id`. The kind bits are: 0 write, 1 instruction, 2 texture, 3 constant, 4 local.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Line address of the miss |
| req_warp | input | WARP_W | Requesting warp |
| req_kind | input | 5 | Kind flags (bit 0 write, 1 instruction, 2 texture, 3 constant, 4 local) |
| req_accept | output | 1 | Request taken this cycle |
| req_id | output | IDX_W | Entry given to the request |
| req_merged | output | 1 | Request linked behind an outstanding entry |
| mem_issue | output | 1 | Request needs its own memory fetch |
| room_need | input | CNT_W+1 | Number of entries asked about |
| room_ok | output | 1 | At least `room_need` entries are free |
| free_count | output | CNT_W | Entries currently free |
| rsp_valid | input | 1 | Memory response present |
| rsp_id | input | IDX_W | Primary entry the response belongs to |
| ret_valid | output | 1 | A return entry is presented |
| ret_pop | input | 1 | Consumer takes the presented entry |
| ret_id | output | IDX_W | Presented entry |
| ret_addr | output | ADDR_W | Address of the presented entry |
| ret_warp | output | WARP_W | Warp of the presented entry |
| ret_kind | output | 5 | Kind flags of the presented entry |
| peak_used | output | CNT_W | Highest occupancy since reset |

## Verification
Merging is tried in four ways: a repeated address with another address interleaved, the same address under the texture flag, an ordinary request to a texture line, and a request to a line that has already been fetched. This separates a correct match rule from one that is too wide or too narrow. Return order is tried with a chain of three entries interleaved with an unrelated primary, and with texture responses that arrive out of order. It is also tried with a texture head that becomes ready before an ordinary primary does; this exposes a wrong priority or an early release. A full fill up to the last entry, with room queries just around the limit and then a full drain, covers the reject case, the freeing path and the peak value.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } ent_st_e;

  localparam int KIND_W   = 5;
  localparam int KIND_TEX = 2;
endpackage

// File: rtl/mshr_pick_low.sv
module mshr_pick_low #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_idq.sv
module mshr_idq #(
  parameter int DEPTH = 16,
  parameter int IDW   = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic           pop,
  output logic [IDW-1:0] head_id,
  output logic           empty
);
  logic [IDW-1:0] slot_q [DEPTH];
  logic [PW-1:0]  wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign head_id = slot_q[rd_q];
  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !do_pop)      cnt_n = cnt_q + CW'(1);
    else if (!do_push && do_pop) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= push_id;
  end
endmodule

// File: rtl/mshr_unit.sv
module mshr_unit #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int WARP_W  = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WARP_W-1:0] req_warp,
  input  logic [4:0]        req_kind,
  output logic              req_accept,
  output logic [IDX_W-1:0]  req_id,
  output logic              req_merged,
  output logic              mem_issue,
  input  logic [CNT_W:0]    room_need,
  output logic              room_ok,
  output logic [CNT_W-1:0]  free_count,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_id,
  output logic              ret_valid,
  input  logic              ret_pop,
  output logic [IDX_W-1:0]  ret_id,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [WARP_W-1:0] ret_warp,
  output logic [4:0]        ret_kind,
  output logic [CNT_W-1:0]  peak_used
);
  import mshr_pkg::*;

  // per-entry state
  ent_st_e           st_q   [ENTRIES];
  ent_st_e           st_n   [ENTRIES];
  logic [ADDR_W-1:0] addr_q [ENTRIES];
  logic [WARP_W-1:0] warp_q [ENTRIES];
  logic [4:0]        kind_q [ENTRIES];
  logic              mrg_q  [ENTRIES];
  logic              mrg_n  [ENTRIES];
  logic              nv_q   [ENTRIES];
  logic              nv_n   [ENTRIES];
  logic [IDX_W-1:0]  nx_q   [ENTRIES];
  logic [IDX_W-1:0]  nx_n   [ENTRIES];
  logic [IDX_W-1:0]  tail_q [ENTRIES];
  logic [IDX_W-1:0]  tail_n [ENTRIES];

  logic [ENTRIES-1:0] free_vec, cand_vec;
  logic               fr_any, mt_any;
  logic [IDX_W-1:0]   fr_idx, mt_idx;
  logic               is_tex_req, do_merge;

  // chain walk state of the normal return path
  logic             walk_q, walk_n;
  logic [IDX_W-1:0] wptr_q, wptr_n;
  logic [CNT_W-1:0] peak_q, peak_n;

  logic             rq_empty, tq_empty, rq_push, rq_pop, tq_push, tq_pop;
  logic [IDX_W-1:0] rq_head, tq_head, norm_id;
  logic             norm_rdy, tex_rdy, pop_any, pop_norm;
  logic             rsp_ok;
  logic [CNT_W-1:0] used_now, used_nxt;

  // candidate vectors
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign free_vec[g] = (st_q[g] == ST_FREE);
    assign cand_vec[g] = (st_q[g] == ST_WAIT) && !mrg_q[g] &&
                         !kind_q[g][KIND_TEX] && (addr_q[g] == req_addr);
  end

  mshr_pick_low #(.N(ENTRIES)) u_free_pick (
    .vec(free_vec), .found(fr_any), .idx(fr_idx)
  );
  mshr_pick_low #(.N(ENTRIES)) u_hit_pick (
    .vec(cand_vec), .found(mt_any), .idx(mt_idx)
  );

  // request side
  assign is_tex_req = req_kind[KIND_TEX];
  assign req_accept = req_valid && fr_any;
  assign do_merge   = req_accept && !is_tex_req && mt_any;
  assign req_merged = do_merge;
  assign mem_issue  = req_accept && !do_merge;
  assign req_id     = fr_idx;

  always_comb begin
    free_count = '0;
    for (int i = 0; i < ENTRIES; i++) free_count = free_count + CNT_W'(free_vec[i]);
  end
  assign room_ok = ({1'b0, free_count} >= room_need);

  // return side
  assign rsp_ok   = rsp_valid && (st_q[rsp_id] == ST_WAIT) && !mrg_q[rsp_id];
  assign rq_push  = rsp_ok && !kind_q[rsp_id][KIND_TEX];
  assign tq_push  = req_accept && is_tex_req;
  assign norm_rdy = walk_q || !rq_empty;
  assign norm_id  = walk_q ? wptr_q : rq_head;
  assign tex_rdy  = !tq_empty && (st_q[tq_head] == ST_DONE);
  assign ret_valid = norm_rdy || tex_rdy;
  assign ret_id    = norm_rdy ? norm_id : tq_head;
  assign ret_addr  = addr_q[ret_id];
  assign ret_warp  = warp_q[ret_id];
  assign ret_kind  = kind_q[ret_id];
  assign pop_any   = ret_pop && ret_valid;
  assign pop_norm  = pop_any && norm_rdy;
  assign rq_pop    = pop_norm && !walk_q;
  assign tq_pop    = pop_any && !norm_rdy;

  mshr_idq #(.DEPTH(ENTRIES), .IDW(IDX_W)) u_ret_q (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .push_id(rsp_id),
    .pop(rq_pop), .head_id(rq_head), .empty(rq_empty)
  );
  mshr_idq #(.DEPTH(ENTRIES), .IDW(IDX_W)) u_tex_q (
    .clk(clk), .rst_n(rst_n), .push(tq_push), .push_id(fr_idx),
    .pop(tq_pop), .head_id(tq_head), .empty(tq_empty)
  );

  // next state
  always_comb begin
    st_n   = st_q;
    mrg_n  = mrg_q;
    nv_n   = nv_q;
    nx_n   = nx_q;
    tail_n = tail_q;
    walk_n = walk_q;
    wptr_n = wptr_q;
    if (pop_norm) begin
      walk_n = nv_q[norm_id];
      wptr_n = nx_q[norm_id];
    end
    if (pop_any) begin
      st_n[ret_id]  = ST_FREE;
      mrg_n[ret_id] = 1'b0;
      nv_n[ret_id]  = 1'b0;
    end
    if (rsp_ok) st_n[rsp_id] = ST_DONE;
    if (req_accept) begin
      st_n[fr_idx]   = ST_WAIT;
      mrg_n[fr_idx]  = do_merge;
      nv_n[fr_idx]   = 1'b0;
      tail_n[fr_idx] = fr_idx;
      if (do_merge) begin
        nv_n[tail_q[mt_idx]] = 1'b1;
        nx_n[tail_q[mt_idx]] = fr_idx;
        tail_n[mt_idx]       = fr_idx;
      end
    end
  end

  assign used_now = CNT_W'(ENTRIES) - free_count;
  assign used_nxt = used_now + CNT_W'(req_accept) - CNT_W'(pop_any);
  assign peak_n   = (used_nxt > peak_q) ? used_nxt : peak_q;
  assign peak_used = peak_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]   <= ST_FREE;
        mrg_q[i]  <= 1'b0;
        nv_q[i]   <= 1'b0;
        nx_q[i]   <= '0;
        tail_q[i] <= '0;
      end
      walk_q <= 1'b0;
      wptr_q <= '0;
      peak_q <= '0;
    end else begin
      st_q   <= st_n;
      mrg_q  <= mrg_n;
      nv_q   <= nv_n;
      nx_q   <= nx_n;
      tail_q <= tail_n;
      walk_q <= walk_n;
      wptr_q <= wptr_n;
      peak_q <= peak_n;
    end
  end

  // payload registers, loaded only on allocation
  always_ff @(posedge clk) begin
    if (req_accept) begin
      addr_q[fr_idx] <= req_addr;
      warp_q[fr_idx] <= req_warp;
      kind_q[fr_idx] <= req_kind;
    end
  end
endmodule

// File: rtl/mshr_unit_chk.sv
module mshr_unit_chk #(
  parameter int ENTRIES = 16,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_accept,
  input logic             ret_valid,
  input logic             ret_pop,
  input logic [CNT_W-1:0] free_count,
  input logic [CNT_W-1:0] peak_used
);
  // R2
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_count == '0) |-> !req_accept);

  // R2
  alloc_takes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && !(ret_pop && ret_valid)) |=> (free_count == $past(free_count) - CNT_W'(1)));

  // R9
  pop_frees_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && ret_valid && !req_accept) |=> (free_count == $past(free_count) + CNT_W'(1)));

  // R10
  peak_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (peak_used >= $past(peak_used)));

  // R10
  peak_covers_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_used >= (CNT_W'(ENTRIES) - free_count));

  // R5
  ret_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (free_count < CNT_W'(ENTRIES)));
endmodule

bind mshr_unit mshr_unit_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .ret_valid(ret_valid),
  .ret_pop(ret_pop), .free_count(free_count), .peak_used(peak_used)
);

// File: tb/tb_mshr_unit.sv
module tb_mshr_unit;
  localparam int ENTRIES = 16;
  localparam int ADDR_W  = 32;
  localparam int WARP_W  = 6;
  localparam int IDX_W   = 4;
  localparam int CNT_W   = 5;

  logic              clk, rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [WARP_W-1:0] req_warp;
  logic [4:0]        req_kind;
  logic              req_accept, req_merged, mem_issue;
  logic [IDX_W-1:0]  req_id;
  logic [CNT_W:0]    room_need;
  logic              room_ok;
  logic [CNT_W-1:0]  free_count, peak_used;
  logic              rsp_valid;
  logic [IDX_W-1:0]  rsp_id;
  logic              ret_valid, ret_pop;
  logic [IDX_W-1:0]  ret_id;
  logic [ADDR_W-1:0] ret_addr;
  logic [WARP_W-1:0] ret_warp;
  logic [4:0]        ret_kind;

  int n_chk, n_bad;

  // reference return queue
  int          mq_id   [64];
  int unsigned mq_addr [64];
  int          mq_warp [64];
  int          mq_kind [64];
  int          mq_wr, mq_rd;

  mshr_unit #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .WARP_W(WARP_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_warp(req_warp), .req_kind(req_kind), .req_accept(req_accept),
    .req_id(req_id), .req_merged(req_merged), .mem_issue(mem_issue),
    .room_need(room_need), .room_ok(room_ok), .free_count(free_count),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .ret_valid(ret_valid),
    .ret_pop(ret_pop), .ret_id(ret_id), .ret_addr(ret_addr),
    .ret_warp(ret_warp), .ret_kind(ret_kind), .peak_used(peak_used)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ret(int id, int unsigned addr, int warp, int kind);
    mq_id[mq_wr] = id; mq_addr[mq_wr] = addr;
    mq_warp[mq_wr] = warp; mq_kind[mq_wr] = kind;
    mq_wr++;
  endtask

  task automatic do_req(int unsigned addr, int warp, int kind,
                        bit exp_acc, int exp_id, bit exp_mrg, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_warp = WARP_W'(warp); req_kind = 5'(kind);
    #2;
    check({tag, " accept"}, req_accept, exp_acc);
    if (exp_acc) begin
      check({tag, " id"}, req_id, exp_id);
      check({tag, " merged"}, req_merged, exp_mrg);
      check({tag, " issue"}, mem_issue, !exp_mrg);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_rsp(int id);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_id = IDX_W'(id);
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  // pop one entry and compare with the reference queue head
  task automatic pop_one(string tag);
    @(negedge clk);
    check({tag, " valid"}, ret_valid, 1);
    check({tag, " id"}, ret_id, mq_id[mq_rd]);
    check({tag, " addr (R11)"}, ret_addr, mq_addr[mq_rd]);
    check({tag, " warp (R11)"}, ret_warp, mq_warp[mq_rd]);
    check({tag, " kind (R11)"}, ret_kind, mq_kind[mq_rd]);
    mq_rd++;
    ret_pop = 1'b1;
    @(posedge clk); #1;
    ret_pop = 1'b0;
  endtask

  task automatic drain(string tag);
    while (mq_rd < mq_wr) pop_one(tag);
    @(negedge clk);
    check({tag, " empty"}, ret_valid, 0);
    mq_rd = 0; mq_wr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 free_count", free_count, ENTRIES);
    check("R1 ret_valid", ret_valid, 0);
    check("R1 peak", peak_used, 0);
    room_need = 6'd16; #1;
    check("R8 need16 at reset", room_ok, 1);
    room_need = 6'd17; #1;
    check("R8 need17 at reset", room_ok, 0);
    room_need = 6'd1;
  endtask

  task automatic t_chain();
    do_req(32'h1000, 3, 0, 1, 0, 0, "R2 first");
    do_req(32'h1000, 4, 0, 1, 1, 1, "R3 merge1");
    do_req(32'h2000, 5, 1, 1, 2, 0, "R3 other addr");
    do_req(32'h1000, 6, 0, 1, 3, 1, "R3 merge2");
    do_rsp(0);
    expect_ret(0, 32'h1000, 3, 0);
    expect_ret(1, 32'h1000, 4, 0);
    expect_ret(3, 32'h1000, 6, 0);
    drain("R5 chain");
    check("R9 free after chain", free_count, 15);
    do_rsp(2);
    expect_ret(2, 32'h2000, 5, 1);
    drain("R5 single");
    check("R9 all free", free_count, 16);
    check("R10 peak 4", peak_used, 4);
  endtask

  task automatic t_texture();
    do_req(32'h3000, 1, 4, 1, 0, 0, "R4 tex first");
    do_req(32'h3000, 2, 4, 1, 1, 0, "R4 tex no merge");
    do_req(32'h3000, 7, 0, 1, 2, 0, "R4 normal vs tex line");
    do_rsp(1);
    @(negedge clk);
    check("R6 young fetched held", ret_valid, 0);
    do_rsp(0);
    expect_ret(0, 32'h3000, 1, 4);
    expect_ret(1, 32'h3000, 2, 4);
    drain("R6 tex order");
    do_rsp(2);
    expect_ret(2, 32'h3000, 7, 0);
    drain("R6 tail normal");
  endtask

  task automatic t_priority();
    do_req(32'h4000, 8, 4, 1, 0, 0, "R7 tex alloc");
    do_req(32'h5000, 9, 0, 1, 1, 0, "R7 normal alloc");
    do_rsp(0);
    @(negedge clk);
    check("R7 tex alone valid", ret_valid, 1);
    check("R7 tex alone id", ret_id, 0);
    do_rsp(1);
    expect_ret(1, 32'h5000, 9, 0);
    expect_ret(0, 32'h4000, 8, 4);
    drain("R7 normal first");
  endtask

  task automatic t_fetched();
    do_req(32'h6000, 10, 0, 1, 0, 0, "R4 base");
    do_rsp(0);
    do_req(32'h6000, 11, 0, 1, 1, 0, "R4 after fetch");
    expect_ret(0, 32'h6000, 10, 0);
    pop_one("R4 pop base");
    do_rsp(1);
    expect_ret(1, 32'h6000, 11, 0);
    drain("R4 second");
  endtask

  task automatic t_fill();
    for (int i = 0; i < ENTRIES; i++) begin
      if (i == 10) begin
        @(negedge clk);
        room_need = 6'd6; #1;
        check("R8 need6 of 6", room_ok, 1);
        room_need = 6'd7; #1;
        check("R8 need7 of 6", room_ok, 0);
        room_need = 6'd1;
      end
      do_req(32'h8000 + i * 32'h40, i, 8, 1, i, 0, "R2 fill");
    end
    @(negedge clk);
    check("R2 free zero", free_count, 0);
    check("R8 need1 full", room_ok, 0);
    check("R10 peak full", peak_used, 16);
    do_req(32'h9999, 0, 0, 0, 0, 0, "R2 full reject");
    @(negedge clk);
    check("R2 reject no change", free_count, 0);
    for (int i = 0; i < ENTRIES; i++) begin
      do_rsp(i);
      expect_ret(i, 32'h8000 + i * 32'h40, i, 8);
    end
    drain("R5 full drain");
    check("R9 refilled", free_count, 16);
    do_req(32'hA000, 2, 16, 1, 0, 0, "R9 reuse lowest");
    do_rsp(0);
    expect_ret(0, 32'hA000, 2, 16);
    drain("R9 reuse ret");
    check("R10 peak kept", peak_used, 16);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; mq_wr = 0; mq_rd = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_warp = '0; req_kind = '0;
    room_need = 6'd1; rsp_valid = 1'b0; rsp_id = '0; ret_pop = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_chain();
    t_texture();
    t_priority();
    t_fetched();
    t_fill();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule